// File: doc/BRIEF.md
# Minimum-Delay Contention-Free Packet Scheduler

This block is the electronic controller of a slotted switch. Each input's packet first crosses a shared bank of K delay lines. A wavelength router then carries it to its output. In every slot the scheduler accepts at most one request per input, and each request names a destination output. For each request it picks a delay between 0 and K-1 slots. That delay, written as a wavelength code, selects the delay line the packet will use.

The delay chosen is the smallest one that keeps the departure slot free of two conflicts:

- a second packet bound for the same output;
- a second packet leaving the delay stage on the same router input.

A packet keeps its port index through the delay stage, so its router input is the input it arrived on. Packets from different inputs may share one delay line in the same slot.

Reservations are held in two circular bitmaps spanning a K-slot horizon: one indexed by output, one indexed by input. A slot pointer steps forward every clock. The column of the slot that has just elapsed is cleared. Requests that arrive in the same slot are served in ascending input order. A request that fits nowhere within the horizon is rejected with a drop flag.

Top module: `mindelay_sched`

## Requirements
- R1: A granted request receives the smallest delay d in 0..K-1 for which its destination output and its own input are both unreserved in slot t+d, where t is the arrival slot.
- R2: No two granted packets depart in the same slot toward the same output.
- R3: No two packets granted on the same input depart in the same slot.
- R4: Requests in one slot are served from input 0 upward. A lower input's grant is visible to higher inputs in that same slot, so four same-slot requests to one idle output get delays 0, 1, 2, 3.
- R5: When no delay in 0..K-1 satisfies R1, the result is drop=1, valid=0 and delay 0. Valid and drop are never both set.
- R6: The wavelength code equals the granted delay. Code 0 selects the zero-length line.
- R7: The result for a request made in one cycle appears in the next cycle. An input with no request shows valid=0 and drop=0 in that next cycle.
- R8: During and right after reset both flags are low and all reservations are empty.
- R9: A reservation lasts only until its slot has passed. After K idle slots, any request again gets delay 0.
- R10: The largest delay, K-1, is granted when every smaller delay is blocked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; one cycle is one packet slot |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | NP | Per-input request flag |
| req_dest | input | NP*OW | Per-input destination output, input i in bits [i*OW +: OW] |
| grant_valid | output | NP | Per-input grant flag |
| grant_drop | output | NP | Per-input reject flag |
| grant_delay | output | NP*DW | Per-input granted delay in slots |
| grant_wave | output | NP*DW | Per-input wavelength code selecting the delay line |

## Verification
The hardest situation to reach from the ports is a fully booked horizon. In that state the only free slot sits at delay K-1, or there is none at all, and the pointer has wrapped around the tables. Directed phases get there by sending every input to one output for many consecutive slots. This fills the output's K columns until grants reach K-1 and then drops begin. Idle slots follow to show the reservations expire. Seeded random traffic, weighted toward few destinations, then mixes per-input and per-output conflicts against a bench model that tracks absolute departure times.

// File: rtl/mindelay_sched.sv
module mindelay_sched #(
  parameter int NP = 4,
  parameter int K  = 35
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic [NP-1:0]                req_valid,
  input  logic [NP*$clog2(NP)-1:0]     req_dest,
  output logic [NP-1:0]                grant_valid,
  output logic [NP-1:0]                grant_drop,
  output logic [NP*$clog2(K)-1:0]      grant_delay,
  output logic [NP*$clog2(K)-1:0]      grant_wave
);
  localparam int OW = $clog2(NP);
  localparam int DW = $clog2(K);

  logic [NP-1:0][K-1:0]  out_res, in_res;
  logic [NP-1:0][K-1:0]  out_acc, in_acc, in_rel;
  logic [NP-1:0][K-1:0]  out_res_n, in_res_n;
  logic [DW-1:0]         ptr;
  logic [NP-1:0]         hit;
  logic [NP-1:0][DW-1:0] dsel;
  logic [NP-1:0][OW-1:0] dest_q;

  function automatic int col_of(input logic [DW-1:0] p, input int d);
    int s;
    s = int'(p) + d;
    if (s >= K) s = s - K;
    return s;
  endfunction

  always_comb begin
    logic [OW-1:0] dst;
    logic          found;
    logic [DW-1:0] sel;
    for (int o = 0; o < NP; o++)
      for (int d = 0; d < K; d++) begin
        out_acc[o][d] = out_res[o][col_of(ptr, d)];
        in_rel[o][d]  = in_res[o][col_of(ptr, d)];
      end
    in_acc = in_rel;
    for (int i = 0; i < NP; i++) begin
      dst   = req_dest[i*OW +: OW];
      found = 1'b0;
      sel   = '0;
      if (req_valid[i])
        for (int d = 0; d < K; d++)
          if (!found && !out_acc[dst][d] && !in_rel[i][d]) begin
            found = 1'b1;
            sel   = DW'(d);
          end
      if (found) begin
        out_acc[dst][sel] = 1'b1;
        in_acc[i][sel]    = 1'b1;
      end
      hit[i]  = found;
      dsel[i] = sel;
    end
    for (int o = 0; o < NP; o++)
      for (int c = 0; c < K; c++) begin
        int r;
        r = c - int'(ptr);
        if (r < 0) r = r + K;
        out_res_n[o][c] = out_acc[o][r] && (c != int'(ptr));
        in_res_n[o][c]  = in_acc[o][r]  && (c != int'(ptr));
      end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_res     <= '0;
      in_res      <= '0;
      ptr         <= '0;
      grant_valid <= '0;
      grant_drop  <= '0;
      grant_delay <= '0;
      dest_q      <= '0;
    end else begin
      out_res     <= out_res_n;
      in_res      <= in_res_n;
      ptr         <= (int'(ptr) == K-1) ? '0 : ptr + 1'b1;
      grant_valid <= hit;
      grant_drop  <= req_valid & ~hit;
      grant_delay <= dsel;
      dest_q      <= req_dest;
    end
  end

  assign grant_wave = grant_delay;

  generate
    for (genvar i = 0; i < NP; i++) begin : g_chk
      assert_flags_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({grant_valid[i], grant_drop[i]}));
      assert_answer_R7: assert property (@(posedge clk) disable iff (!rst_n)
        req_valid[i] |=> (grant_valid[i] || grant_drop[i]));
      assert_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !req_valid[i] |=> (!grant_valid[i] && !grant_drop[i]));
      assert_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
        grant_valid[i] |-> (int'(grant_delay[i*DW +: DW]) < K));
      for (genvar j = i + 1; j < NP; j++) begin : g_pair
        assert_out_unique_R2: assert property (@(posedge clk) disable iff (!rst_n)
          (grant_valid[i] && grant_valid[j] && dest_q[i] == dest_q[j])
            |-> (grant_delay[i*DW +: DW] != grant_delay[j*DW +: DW]));
      end
    end
  endgenerate
endmodule

// File: tb/mindelay_sched_bench.sv
module mindelay_sched_bench;
  localparam int NP = 4;
  localparam int K  = 35;
  localparam int OW = $clog2(NP);
  localparam int DW = $clog2(K);
  localparam int TM = 4096;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [NP-1:0] req_valid = '0;
  logic [NP*OW-1:0] req_dest = '0;
  logic [NP-1:0] grant_valid, grant_drop;
  logic [NP*DW-1:0] grant_delay, grant_wave;

  int checks = 0, errors = 0, t = 0;
  bit done = 1'b0;
  bit pending = 1'b0;
  bit mob [NP][TM];
  bit mib [NP][TM];
  bit ev [NP];
  bit ed [NP];
  int edl [NP];
  string ptag = "R1";

  always #5 clk = ~clk;

  mindelay_sched #(.NP(NP), .K(K)) u_mindelay_sched (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_dest(req_dest),
    .grant_valid(grant_valid), .grant_drop(grant_drop),
    .grant_delay(grant_delay), .grant_wave(grant_wave));

  task automatic chk(input string tag, input int act, input int exp, input string what);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  function automatic int model_pick(input int i, input int dst);
    for (int d = 0; d < K; d++)
      if (!mob[dst][t+d] && !mib[i][t+d]) return d;
    return -1;
  endfunction

  task automatic step(input logic [NP-1:0] v, input logic [NP*OW-1:0] ds, input string tag);
    @(negedge clk);
    if (pending)
      for (int i = 0; i < NP; i++) begin
        chk(ev[i] || ed[i] ? ptag : "R7", int'(grant_valid[i]), int'(ev[i]), "valid");
        chk(ed[i] ? "R5" : ptag, int'(grant_drop[i]), int'(ed[i]), "drop");
        if (ev[i] || ed[i])
          chk(ptag, int'(grant_delay[i*DW +: DW]), edl[i], "delay");
        chk("R6", int'(grant_wave[i*DW +: DW]), int'(grant_delay[i*DW +: DW]), "wave");
      end
    t++;
    req_valid = v;
    req_dest  = ds;
    ptag = tag;
    for (int i = 0; i < NP; i++) begin
      int d, dst;
      dst = int'(ds[i*OW +: OW]);
      ev[i] = 1'b0; ed[i] = 1'b0; edl[i] = 0;
      if (v[i]) begin
        d = model_pick(i, dst);
        if (d < 0) ed[i] = 1'b1;
        else begin
          ev[i] = 1'b1; edl[i] = d;
          mob[dst][t+d] = 1'b1;
          mib[i][t+d]   = 1'b1;
        end
      end
    end
    pending = 1'b1;
  endtask

  initial begin
    void'($urandom(20240611));
    repeat (3) @(negedge clk);
    for (int i = 0; i < NP; i++) begin
      chk("R8", int'(grant_valid[i]), 0, "reset valid");
      chk("R8", int'(grant_drop[i]), 0, "reset drop");
    end
    rst_n = 1'b1;
    step(4'b0001, {2'd0, 2'd0, 2'd0, 2'd2}, "R1");
    step(4'b1111, {2'd1, 2'd1, 2'd1, 2'd1}, "R4");
    step(4'b0000, '0, "R7");
    for (int n = 0; n < 20; n++) step(4'b1111, {2'd3, 2'd3, 2'd3, 2'd3}, "R10");
    for (int n = 0; n < 4; n++) step(4'b1111, {2'd3, 2'd3, 2'd3, 2'd3}, "R5");
    for (int n = 0; n < K + 1; n++) step(4'b0000, '0, "R9");
    step(4'b0101, {2'd3, 2'd3, 2'd3, 2'd3}, "R9");
    step(4'b1010, {2'd0, 2'd0, 2'd0, 2'd0}, "R3");
    for (int n = 0; n < 1500; n++) begin
      logic [NP-1:0] v;
      logic [NP*OW-1:0] ds;
      for (int i = 0; i < NP; i++) begin
        v[i] = ($urandom % 100) < 70;
        ds[i*OW +: OW] = OW'(($urandom % 3 == 0) ? $urandom % NP : 0);
      end
      step(v, ds, n % 2 == 0 ? "R1" : "R2");
    end
    step(4'b0000, '0, "R7");
    step(4'b0000, '0, "R7");
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=running expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule